// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

A clocked single-port static memory with an internal two-bit burst sequencer. It is meant to stand in for a burst-capable synchronous SRAM beside a processor or cache controller. Every control input except output enable and sleep is sampled on the rising clock edge. An access starts from either of two address strobes: one is owned by the processor side and one by the controller side. Later words of the burst come from the sequencer each time the advance input is held low. The low two address bits step in linear order or interleaved order, and a mode input picks the order while the block runs.

Reads can be delivered in one of two ways. In flow-through mode the data comes straight from the access stage, one clock after the command. In pipelined mode it passes through one more output register and arrives two clocks after the command. A deselect goes through the same stages, so the outputs turn off with the same latency as a read. Writes happen in the cycle of the command and are masked per byte lane. The data bus is split into an input port and an output port, and a valid flag marks when the output would drive.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is held and after it is released, `dout_en` is 0 and `dout` is 0 until a read is issued.
- R2: A strobe low on a rising edge (`strb_cpu_n` or `strb_ctl_n`) loads `addr` and starts an access at that address. A new strobe is accepted on every cycle.
- R3: With no strobe, an active burst moves to its next word only when `adv_n` is 0. With `adv_n` at 1, the same word is accessed again.
- R4: The word offset is formed from the two low start bits `b` and the step count `c`. It is `(b + c) mod 4` when `lin_n` is 0 (linear) and `b XOR c` when `lin_n` is 1 (interleaved).
- R5: After four advances the step count comes back to zero, so the fifth word equals the first.
- R6: With `pipe_mode` at 0, read data and `dout_en` show up after the edge that samples the read. With `pipe_mode` at 1 they show up one edge later.
- R7: A write is requested when `gw_n` is 0 (all lanes) or when `bwe_n` is 0 and at least one `bsel_n` bit is 0. Lane i is bits 8i+7..8i and is written only when `bsel_n[i]` is 0. With no write request the access is a read.
- R8: A deselect has the same latency as a read. A deselect is a strobe start whose chip enables are not all active. In pipelined mode `dout_en` is still 1 after the first edge following the deselect and drops after the second.
- R9: `strb_cpu_n` is ignored when `ce1_n` is 1. It is also ignored when `strb_ctl_n` is 0 with no write request. A processor-side start checks only `ce1_n` and `ce2`. A controller-side start also needs `ce3_n` at 0.
- R10: When both strobes are low and a write is requested, the processor-side start wins. It acts as a read, and nothing is written.
- R11: `oe_n` at 1 forces `dout_en` and `dout` to 0 without waiting for a clock. The internal state is not changed.
- R12: While `sleep` is 1, `dout_en` is 0 and no edge changes the memory, the burst state or the read stages. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address |
| din | input | 8*LANES | Write data |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low, used only with the controller strobe |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Suspend, active high |
| lin_n | input | 1 | 0 selects linear burst order, 1 selects interleaved |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 selects flow-through |
| dout | output | 8*LANES | Read data, 0 when not enabled |
| dout_en | output | 1 | Output would drive |

## Verification
Two things can fall in the same cycle: the start of a new access on one strobe, and a competing start on the other strobe or a burst advance. The bench drives both strobes low in one cycle under two conditions. With no write request and `ce3_n` inactive, the controller deselect must win and the output must go off. With a write request, the processor-side read must win: its data must appear, and a later read must show the word unchanged. Overlapping commands are also checked: a deselect issued while a pipelined read is still in flight must leave that read's data visible for exactly one more edge.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [8*LANES-1:0]   din,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 ce3_n,
  input  logic                 strb_cpu_n,
  input  logic                 strb_ctl_n,
  input  logic                 adv_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bsel_n,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic                 lin_n,
  input  logic                 pipe_mode,
  output logic [8*LANES-1:0]   dout,
  output logic                 dout_en
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          act;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic          v1, v2;
  logic [DW-1:0] d1, d2;

  wire wr_req = !gw_n || (!bwe_n && !(&bsel_n));
  wire [LANES-1:0] lane_we = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bsel_n : {LANES{1'b0}});
  wire ctl_rd = !strb_ctl_n && !wr_req;
  wire cpu_go = !strb_cpu_n && !ce1_n && !ctl_rd;
  wire ctl_go = !cpu_go && !strb_ctl_n;
  wire start  = cpu_go || ctl_go;
  wire sel    = cpu_go ? ce2 : (!ce1_n && ce2 && !ce3_n);
  wire step   = !start && act && !adv_n;
  wire [1:0] nxt_cnt = step ? cnt + 2'd1 : cnt;
  wire [1:0] off     = lin_n ? (base[1:0] ^ nxt_cnt) : (base[1:0] + nxt_cnt);
  wire [AW-1:0] a_eff = start ? addr : {base[AW-1:2], off};
  wire acc    = start ? sel : act;
  wire do_wr  = acc && wr_req && !cpu_go;
  wire do_rd  = acc && !do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      base <= '0;
      cnt  <= 2'd0;
      v1   <= 1'b0;
      v2   <= 1'b0;
    end else if (!sleep) begin
      if (start) begin
        act  <= sel;
        base <= addr;
        cnt  <= 2'd0;
      end else begin
        cnt  <= nxt_cnt;
      end
      if (start || act) v1 <= do_rd;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) begin
      if (do_rd) d1 <= mem[a_eff];
      d2 <= d1;
      if (do_wr)
        for (int i = 0; i < LANES; i++)
          if (lane_we[i]) mem[a_eff][8*i +: 8] <= din[8*i +: 8];
    end
  end

  wire          qv = pipe_mode ? v2 : v1;
  wire [DW-1:0] q  = pipe_mode ? d2 : d1;
  assign dout_en = qv && !oe_n && !sleep;
  assign dout    = dout_en ? q : '0;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && start) |=> (cnt == 2'd0 && base == $past(addr)));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && step && cnt == 2'd3) |=> (cnt == 2'd0));
  a_r8_dcd: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !v1) |=> !v2);
  a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && dout == '0));
  a_r12_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cnt) && $stable(act) && $stable(v1) && $stable(v2)));
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic [31:0] din = 0;
  logic ce1_n, ce2, ce3_n, strb_cpu_n, strb_ctl_n, adv_n, gw_n, bwe_n;
  logic [3:0] bsel_n;
  logic oe_n, sleep, lin_n = 1, pipe_mode = 0;
  logic [31:0] dout;
  logic dout_en;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  sync_burst_sram i_sync_burst_sram (.*);

  function automatic logic [31:0] f(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, a + 8'd1};
  endfunction

  task automatic idle();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
    ce1_n = 0; ce2 = 1; ce3_n = 0; sleep = 0; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic chkd(input string r, input logic [31:0] e);
    chk(dout_en === 1'b1 && dout === e, r, dout, e);
  endtask

  task automatic chkoff(input string r);
    chk(dout_en === 1'b0 && dout === 32'h0, r, {31'h0, dout_en}, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    idle(); strb_ctl_n = 0; addr = a; din = d; gw_n = 0; tick(); idle();
  endtask

  task automatic rd_ctl(input logic [7:0] a);
    idle(); strb_ctl_n = 0; addr = a; tick(); idle();
  endtask

  task automatic rd_cpu(input logic [7:0] a);
    idle(); strb_cpu_n = 0; addr = a; tick(); idle();
  endtask

  task automatic t_reset();
    idle(); #1;
    chkoff("R1 during reset");
    tick(); rst_n = 1; tick();
    chkoff("R1 after reset");
  endtask

  task automatic t_fill_and_flow();
    pipe_mode = 0;
    for (int a = 8'h20; a < 8'h30; a++) wr(a[7:0], f(a[7:0]));
    rd_ctl(8'h21); chkd("R2 R6 flow ctl read", f(8'h21));
    rd_cpu(8'h22); chkd("R2 R6 flow cpu read", f(8'h22));
  endtask

  task automatic t_pipe();
    pipe_mode = 1;
    idle(); strb_cpu_n = 0; addr = 8'h24; tick();
    addr = 8'h25; tick(); chkd("R6 pipe latency 0x24", f(8'h24));
    addr = 8'h26; tick(); chkd("R2 pipe back-to-back 0x25", f(8'h25));
    idle(); tick(); chkd("R6 pipe last 0x26", f(8'h26));
    pipe_mode = 0;
  endtask

  task automatic t_burst_lin();
    lin_n = 0;
    rd_ctl(8'h26); chkd("R4 lin start", f(8'h26));
    adv_n = 0; tick(); chkd("R4 lin step1", f(8'h27));
    adv_n = 1; tick(); chkd("R3 hold without advance", f(8'h27));
    adv_n = 0; tick(); chkd("R4 lin step2 wrap in line", f(8'h24));
    tick(); chkd("R4 lin step3", f(8'h25));
    tick(); chkd("R5 fifth equals first", f(8'h26));
    idle(); lin_n = 1;
  endtask

  task automatic t_burst_il();
    lin_n = 1;
    rd_cpu(8'h2D); chkd("R4 il start", f(8'h2D));
    adv_n = 0; tick(); chkd("R4 il step1", f(8'h2C));
    tick(); chkd("R4 il step2", f(8'h2F));
    tick(); chkd("R4 il step3", f(8'h2E));
    tick(); chkd("R5 il wrap", f(8'h2D));
    idle();
  endtask

  task automatic t_bytes();
    wr(8'h30, 32'h11223344);
    idle(); strb_ctl_n = 0; addr = 8'h30; din = 32'hAABBCCDD; bwe_n = 0; bsel_n = 4'b1010; tick(); idle();
    rd_ctl(8'h30); chkd("R7 lanes 0 and 2 written", 32'h11BB33DD);
    idle(); strb_ctl_n = 0; addr = 8'h30; din = 32'hFFFFFFFF; bsel_n = 4'h0; tick(); idle();
    chkd("R7 no enable means read", 32'h11BB33DD);
    idle(); strb_ctl_n = 0; addr = 8'h30; din = 32'h55667788; gw_n = 0; bwe_n = 0; tick(); idle();
    rd_ctl(8'h30); chkd("R7 global write ignores lanes", 32'h55667788);
  endtask

  task automatic t_dcd();
    pipe_mode = 1;
    idle(); strb_ctl_n = 0; addr = 8'h21; tick();
    ce2 = 0; tick(); chkd("R8 pipe still driving after first edge", f(8'h21));
    idle(); tick(); chkoff("R8 pipe off after second edge");
    pipe_mode = 0;
    rd_ctl(8'h22); chkd("R8 flow read", f(8'h22));
    idle(); strb_ctl_n = 0; ce2 = 0; tick(); idle(); chkoff("R8 flow off after one edge");
  endtask

  task automatic t_mask();
    rd_ctl(8'h22); chkd("R9 base read", f(8'h22));
    idle(); strb_cpu_n = 0; ce1_n = 1; addr = 8'h21; tick(); idle();
    chkd("R9 cpu strobe masked by ce1", f(8'h22));
    idle(); strb_cpu_n = 0; ce3_n = 1; addr = 8'h23; tick(); idle();
    chkd("R9 cpu start ignores ce3", f(8'h23));
    idle(); strb_cpu_n = 0; strb_ctl_n = 0; ce3_n = 1; addr = 8'h24; tick(); idle();
    chkoff("R9 ctl read masks cpu strobe");
    idle(); strb_cpu_n = 0; strb_ctl_n = 0; gw_n = 0; din = 32'hDEADBEEF; addr = 8'h24; tick(); idle();
    chkd("R10 cpu wins and reads", f(8'h24));
    rd_ctl(8'h24); chkd("R10 no write happened", f(8'h24));
  endtask

  task automatic t_oe();
    oe_n = 1; #1; chkoff("R11 oe high gates outputs");
    oe_n = 0; #1; chkd("R11 oe low restores data", f(8'h24));
  endtask

  task automatic t_sleep();
    lin_n = 0;
    rd_ctl(8'h20); chkd("R12 pre-sleep read", f(8'h20));
    sleep = 1; adv_n = 0; #1; chkoff("R12 outputs off in sleep");
    tick();
    strb_ctl_n = 0; gw_n = 0; addr = 8'h20; din = 32'h0; tick();
    idle(); adv_n = 0; tick(); chkd("R12 counter held across sleep", f(8'h21));
    rd_ctl(8'h20); chkd("R12 data retained", f(8'h20));
    lin_n = 1;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    report();
  end

  initial begin
    idle();
    t_reset();
    t_fill_and_flow();
    t_pipe();
    t_burst_lin();
    t_burst_il();
    t_bytes();
    t_dcd();
    t_mask();
    t_oe();
    t_sleep();
    report();
  end
endmodule